// File: doc/BRIEF.md
# Flash Erase Sequencer with Suspend and Forced Abort

This block runs block-erase and program operations on a block-organised flash array. The array is modelled as a countdown whose length comes from two duration inputs. An erase may be paused and later resumed through a suspend-request bit. Software can write that bit, and when automatic suspend is enabled, a maskable interrupt acknowledge sets it. A paused erase keeps its remaining cycle count, so a resumed erase finishes after exactly the time it still had left. Reads are permitted while the sequencer is idle. While an erase is paused, reads are permitted to every block except the one being erased.

A non-maskable interrupt acknowledge stops any operation at once: an erase in any phase, or a program. The flash then spends a fixed restart period resetting. The block or address that was being worked on is flagged as holding undefined data until an erase of that block completes normally. A program operation cannot be paused.

The state machine has six states. IDLE accepts commands. ERASING counts down the erase. SUSPENDING waits out the suspend latency. SUSPENDED holds the erase with its count frozen. PROGRAMMING counts down a program. RESETTING is the restart period after an abort.

The transitions are:
- start-erase: IDLE to ERASING.
- start-program: IDLE to PROGRAMMING.
- erase-done: ERASING to IDLE.
- program-done: PROGRAMMING to IDLE.
- pause: ERASING to SUSPENDING.
- latency-over: SUSPENDING to SUSPENDED.
- resume: SUSPENDED to ERASING.
- abort: any of ERASING, SUSPENDING, SUSPENDED or PROGRAMMING to RESETTING.
- restart-over: RESETTING to IDLE.

Top module: `flash_erase_sequencer`

## Requirements
- R1: In IDLE, `cmd_erase` enters ERASING for max(`erase_cycles`,1) cycles and `cmd_prog` enters PROGRAMMING for max(`prog_cycles`,1) cycles. The machine then returns to IDLE, and `done` is high for exactly the first IDLE cycle.
- R2: While ERASING, if `auto_sus_en`=1, an `irq_ack_mask` pulse sets `sus_req` in the next cycle. If `auto_sus_en`=0, the pulse leaves `sus_req` unchanged.
- R3: During ERASING, SUSPENDING or SUSPENDED, a `sus_wr_en` pulse loads `sus_req` with `sus_wr_val`. In every other state, `sus_req` is forced to 0 on the next edge and writes have no effect.
- R4: ERASING with `sus_req`=1 moves to SUSPENDING. The machine stays there for exactly SUS_LAT cycles and then enters SUSPENDED.
- R5: `rd_ok` is 1 in IDLE for any `rd_blk`. In SUSPENDED it is 1 only when `rd_blk` differs from the block being erased. In every other state it is 0.
- R6: In SUSPENDED, clearing `sus_req` returns the machine to ERASING on the next edge. Erase cycles spent before and after the pause add up to the original length plus the one cycle in which the pause was taken.
- R7: Programming cannot be paused. During PROGRAMMING, `sus_req` stays 0 and the program lasts its full length.
- R8: `irq_ack_nmi` in ERASING, SUSPENDING, SUSPENDED or PROGRAMMING moves the machine to RESETTING on the next edge. It stays there for exactly RST_CYC cycles, then returns to IDLE with no `done`.
- R9: An abort sets bit b of `blk_undef`, where b is the active block. The bit clears only when a later erase of block b completes normally. Programming never clears it.
- R10: `state_oh` is one-hot with IDLE=bit0, ERASING=bit1, SUSPENDING=bit2, SUSPENDED=bit3, PROGRAMMING=bit4 and RESETTING=bit5. The reset value is IDLE, with `sus_req`, `done` and `blk_undef` all 0.
- R11: Commands are ignored outside IDLE. When `cmd_erase` and `cmd_prog` arrive together in IDLE, the erase is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_erase | input | 1 | Start a block erase (IDLE only) |
| cmd_prog | input | 1 | Start a program (IDLE only) |
| cmd_blk | input | BLK_W | Target block of the command |
| erase_cycles | input | CNT_W | Erase duration in cycles (0 treated as 1) |
| prog_cycles | input | CNT_W | Program duration in cycles (0 treated as 1) |
| auto_sus_en | input | 1 | Let maskable acknowledges raise the suspend request |
| sus_wr_en | input | 1 | Software write strobe for the suspend request |
| sus_wr_val | input | 1 | Value written to the suspend request |
| irq_ack_mask | input | 1 | Maskable-class interrupt acknowledge |
| irq_ack_nmi | input | 1 | Non-maskable-class interrupt acknowledge |
| rd_blk | input | BLK_W | Block a read would address |
| rd_ok | output | 1 | Read to `rd_blk` is permitted now |
| sus_req | output | 1 | Suspend-request bit |
| state_oh | output | 6 | One-hot state |
| done | output | 1 | One-cycle pulse on normal completion |
| blk_undef | output | NBLK | Per-block undefined-content flags |

## Verification
The bench targets several corner cases:
- A pause taken mid-erase. A design that let the count run on during the pause, or that reloaded it on resume, would finish early or late.
- The suspend latency window. An off-by-one here shows up as a SUSPENDING phase one cycle short or long.
- Read permission while paused, for the erased block and for a neighbour. A wrong compare grants the erased block.
- Abort from SUSPENDED and from PROGRAMMING. A design that skipped the restart period, or forgot the undefined flag, shows in the RESETTING length and in `blk_undef`.
- Auto-suspend with the enable low.
- A suspend write during programming.
- Simultaneous commands.
- A zero duration. Done wrongly, it could leave the counter wrapping for 65536 cycles.

Random traffic is compared every cycle against a bench reference model.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [2:0] {
        S_IDLE       = 3'd0,
        S_ERASE      = 3'd1,
        S_SUSPENDING = 3'd2,
        S_SUSPENDED  = 3'd3,
        S_PROG       = 3'd4,
        S_RESET      = 3'd5
    } fes_state_e;

    localparam int NSTATE = 6;

    function automatic logic [NSTATE-1:0] state_onehot(input fes_state_e s);
        logic [NSTATE-1:0] r;
        r = '0;
        r[s] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/fes_array_model.sv
module fes_array_model #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             last
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= (load_val == '0) ? CNT_W'(1) : load_val;
        end else if (run && remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign last = (remain == CNT_W'(1));

    // R6: remaining time is frozen whenever the array is neither loaded nor run
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(remain));

endmodule

// File: rtl/fes_sus_bit.sv
module fes_sus_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic erase_phase,
    input  logic in_erase,
    input  logic auto_sus_en,
    input  logic irq_ack_mask,
    input  logic sus_wr_en,
    input  logic sus_wr_val,
    output logic sus_req
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sus_req <= 1'b0;
        end else if (!erase_phase) begin
            sus_req <= 1'b0;
        end else if (auto_sus_en && irq_ack_mask && in_erase) begin
            sus_req <= 1'b1;
        end else if (sus_wr_en) begin
            sus_req <= sus_wr_val;
        end
    end

    // R2: an acknowledge with auto-suspend enabled during erase raises the request
    assert_auto_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_erase && auto_sus_en && irq_ack_mask) |=> sus_req);

endmodule

// File: rtl/fes_fsm.sv
module fes_fsm
    import fes_pkg::*;
#(
    parameter int NBLK    = 8,
    parameter int SUS_LAT = 20,
    parameter int RST_CYC = 30,
    localparam int BLK_W  = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int TMR_MAX = (SUS_LAT > RST_CYC) ? SUS_LAT : RST_CYC,
    localparam int TMR_W  = $clog2(TMR_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_erase,
    input  logic              cmd_prog,
    input  logic [BLK_W-1:0]  cmd_blk,
    input  logic              sus_req,
    input  logic              nmi,
    input  logic              op_last,
    output logic [NSTATE-1:0] state_oh,
    output logic              ld_erase,
    output logic              ld_prog,
    output logic              run,
    output logic              erase_phase,
    output logic              in_erase,
    output logic              done,
    output logic [BLK_W-1:0]  act_blk,
    output logic [NBLK-1:0]   blk_undef
);
    fes_state_e       st, nxt;
    logic [TMR_W-1:0] tmr;
    logic             fin, abort, pause;

    always_comb begin
        nxt      = st;
        ld_erase = 1'b0;
        ld_prog  = 1'b0;
        run      = 1'b0;
        fin      = 1'b0;
        abort    = 1'b0;
        pause    = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (cmd_erase) begin
                    nxt = S_ERASE;
                    ld_erase = 1'b1;
                end else if (cmd_prog) begin
                    nxt = S_PROG;
                    ld_prog = 1'b1;
                end
            end
            S_ERASE: begin
                if (nmi) begin
                    nxt = S_RESET;
                    abort = 1'b1;
                end else if (sus_req) begin
                    nxt = S_SUSPENDING;
                    pause = 1'b1;
                end else begin
                    run = 1'b1;
                    if (op_last) begin
                        nxt = S_IDLE;
                        fin = 1'b1;
                    end
                end
            end
            S_SUSPENDING: begin
                if (nmi) begin
                    nxt = S_RESET;
                    abort = 1'b1;
                end else if (tmr == TMR_W'(1)) begin
                    nxt = S_SUSPENDED;
                end
            end
            S_SUSPENDED: begin
                if (nmi) begin
                    nxt = S_RESET;
                    abort = 1'b1;
                end else if (!sus_req) begin
                    nxt = S_ERASE;
                end
            end
            S_PROG: begin
                if (nmi) begin
                    nxt = S_RESET;
                    abort = 1'b1;
                end else begin
                    run = 1'b1;
                    if (op_last) begin
                        nxt = S_IDLE;
                        fin = 1'b1;
                    end
                end
            end
            S_RESET: begin
                if (tmr == TMR_W'(1)) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            tmr       <= '0;
            done      <= 1'b0;
            act_blk   <= '0;
            blk_undef <= '0;
        end else begin
            st   <= nxt;
            done <= fin;
            if (ld_erase || ld_prog) act_blk <= cmd_blk;
            if (abort) blk_undef[act_blk] <= 1'b1;
            else if (fin && st == S_ERASE) blk_undef[act_blk] <= 1'b0;
            if (abort) tmr <= TMR_W'(RST_CYC);
            else if (pause) tmr <= TMR_W'(SUS_LAT);
            else if (tmr != '0) tmr <= tmr - TMR_W'(1);
        end
    end

    always_comb begin
        state_oh    = state_onehot(st);
        in_erase    = (st == S_ERASE);
        erase_phase = (st == S_ERASE) || (st == S_SUSPENDING) || (st == S_SUSPENDED);
    end

    // R10: exactly one state bit
    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh) == 1);
    // R8: abort from any busy state
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi && (state_oh[1] || state_oh[2] || state_oh[3] || state_oh[4])) |=> state_oh[5]);
    // R4: a pending request pauses the erase
    assert_pause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[1] && sus_req && !nmi) |=> state_oh[2]);
    // R6: clearing the request in SUSPENDED resumes
    assert_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[3] && !sus_req && !nmi) |=> state_oh[1]);
    // R1: done only accompanies the first IDLE cycle
    assert_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state_oh[0]);
    // R11: a running program ignores commands and keeps going
    assert_prog_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[4] && !nmi && !op_last) |=> state_oh[4]);

endmodule

// File: rtl/flash_erase_sequencer.sv
module flash_erase_sequencer
    import fes_pkg::*;
#(
    parameter int NBLK    = 8,
    parameter int CNT_W   = 16,
    parameter int SUS_LAT = 20,
    parameter int RST_CYC = 30,
    localparam int BLK_W  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_erase,
    input  logic              cmd_prog,
    input  logic [BLK_W-1:0]  cmd_blk,
    input  logic [CNT_W-1:0]  erase_cycles,
    input  logic [CNT_W-1:0]  prog_cycles,
    input  logic              auto_sus_en,
    input  logic              sus_wr_en,
    input  logic              sus_wr_val,
    input  logic              irq_ack_mask,
    input  logic              irq_ack_nmi,
    input  logic [BLK_W-1:0]  rd_blk,
    output logic              rd_ok,
    output logic              sus_req,
    output logic [NSTATE-1:0] state_oh,
    output logic              done,
    output logic [NBLK-1:0]   blk_undef
);
    logic             ld_erase, ld_prog, run, op_last, erase_phase, in_erase;
    logic [BLK_W-1:0] act_blk;

    fes_fsm #(.NBLK(NBLK), .SUS_LAT(SUS_LAT), .RST_CYC(RST_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_erase(cmd_erase), .cmd_prog(cmd_prog), .cmd_blk(cmd_blk),
        .sus_req(sus_req), .nmi(irq_ack_nmi), .op_last(op_last),
        .state_oh(state_oh), .ld_erase(ld_erase), .ld_prog(ld_prog), .run(run),
        .erase_phase(erase_phase), .in_erase(in_erase),
        .done(done), .act_blk(act_blk), .blk_undef(blk_undef)
    );

    fes_array_model #(.CNT_W(CNT_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .load(ld_erase || ld_prog),
        .load_val(ld_erase ? erase_cycles : prog_cycles),
        .run(run), .last(op_last)
    );

    fes_sus_bit u_sus (
        .clk(clk), .rst_n(rst_n),
        .erase_phase(erase_phase), .in_erase(in_erase),
        .auto_sus_en(auto_sus_en), .irq_ack_mask(irq_ack_mask),
        .sus_wr_en(sus_wr_en), .sus_wr_val(sus_wr_val),
        .sus_req(sus_req)
    );

    assign rd_ok = state_oh[0] || (state_oh[3] && (rd_blk != act_blk));

    // R7: the request bit never stands while programming
    assert_prog_nosus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_oh[4] |-> !sus_req);
    // R5: no reads while the array is actively busy
    assert_busy_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[1] || state_oh[4] || state_oh[5]) |-> !rd_ok);

endmodule

// File: tb/sim_flash_erase_sequencer.sv
module sim_flash_erase_sequencer;
    localparam int NBLK = 8, CNT_W = 16, SUS_LAT = 20, RST_CYC = 30, BLK_W = 3;

    logic clk = 0, rst_n = 0;
    logic cmd_erase = 0, cmd_prog = 0, auto_sus_en = 0, sus_wr_en = 0, sus_wr_val = 0;
    logic irq_ack_mask = 0, irq_ack_nmi = 0;
    logic [BLK_W-1:0] cmd_blk = 0, rd_blk = 0;
    logic [CNT_W-1:0] erase_cycles = 0, prog_cycles = 0;
    logic rd_ok, sus_req, done;
    logic [5:0] state_oh;
    logic [NBLK-1:0] blk_undef;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    flash_erase_sequencer #(.NBLK(NBLK), .CNT_W(CNT_W), .SUS_LAT(SUS_LAT), .RST_CYC(RST_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_erase(cmd_erase), .cmd_prog(cmd_prog), .cmd_blk(cmd_blk),
        .erase_cycles(erase_cycles), .prog_cycles(prog_cycles), .auto_sus_en(auto_sus_en),
        .sus_wr_en(sus_wr_en), .sus_wr_val(sus_wr_val), .irq_ack_mask(irq_ack_mask),
        .irq_ack_nmi(irq_ack_nmi), .rd_blk(rd_blk), .rd_ok(rd_ok), .sus_req(sus_req),
        .state_oh(state_oh), .done(done), .blk_undef(blk_undef));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // reference model, built from the requirements
    int m_st = 0, m_rem = 0, m_tmr = 0, m_act = 0, n_st;
    logic m_sus = 0, m_done = 0, n_sus;
    logic [NBLK-1:0] m_undef = 0;
    bit mdl_en = 0;

    function automatic int at_least1(input logic [CNT_W-1:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_rem = 0; m_tmr = 0; m_act = 0; m_sus = 0; m_done = 0; m_undef = 0;
        end else begin
            n_st = m_st; m_done = 0;
            if (!(m_st >= 1 && m_st <= 3)) n_sus = 0;
            else if (auto_sus_en && irq_ack_mask && m_st == 1) n_sus = 1;
            else if (sus_wr_en) n_sus = sus_wr_val;
            else n_sus = m_sus;
            if (irq_ack_nmi && m_st >= 1 && m_st <= 4) begin
                n_st = 5; m_tmr = RST_CYC; m_undef[m_act] = 1;
            end else begin
                case (m_st)
                    0: if (cmd_erase) begin n_st = 1; m_rem = at_least1(erase_cycles); m_act = int'(cmd_blk); end
                       else if (cmd_prog) begin n_st = 4; m_rem = at_least1(prog_cycles); m_act = int'(cmd_blk); end
                    1: if (m_sus) begin n_st = 2; m_tmr = SUS_LAT; end
                       else begin
                           if (m_rem == 1) begin n_st = 0; m_done = 1; m_undef[m_act] = 0; end
                           m_rem--;
                       end
                    2: begin if (m_tmr == 1) n_st = 3; m_tmr--; end
                    3: if (!m_sus) n_st = 1;
                    4: begin if (m_rem == 1) begin n_st = 0; m_done = 1; end m_rem--; end
                    5: begin if (m_tmr == 1) n_st = 0; m_tmr--; end
                    default: n_st = 0;
                endcase
            end
            m_st = n_st; m_sus = n_sus;
        end
    end

    always @(negedge clk) begin
        #2;
        if (mdl_en && rst_n) begin
            chk("R10 model state", 32'(state_oh), 32'(6'd1 << m_st));
            chk("R1 model done", 32'(done), 32'(m_done));
            chk("R3 model sus_req", 32'(sus_req), 32'(m_sus));
            chk("R9 model blk_undef", 32'(blk_undef), 32'(m_undef));
            chk("R5 model rd_ok", 32'(rd_ok), 32'(m_st == 0 || (m_st == 3 && int'(rd_blk) != m_act)));
        end
    end

    task automatic count_in(input int b, output int n);
        n = 0;
        while (state_oh[b] && n < 100000) begin n++; @(negedge clk); end
    endtask

    task automatic start_erase(input int blk, input int cyc);
        cmd_erase = 1; cmd_blk = BLK_W'(blk); erase_cycles = CNT_W'(cyc);
        @(negedge clk); cmd_erase = 0;
    endtask

    task automatic start_prog(input int blk, input int cyc);
        cmd_prog = 1; cmd_blk = BLK_W'(blk); prog_cycles = CNT_W'(cyc);
        @(negedge clk); cmd_prog = 0;
    endtask

    task automatic pulse_sus(input logic v);
        sus_wr_en = 1; sus_wr_val = v; @(negedge clk); sus_wr_en = 0;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        wrap_up();
    end

    initial begin
        int n, pre;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        mdl_en = 1;
        #1;
        chk("R10 reset state", 32'(state_oh), 32'h1);
        chk("R10 reset sus_req", 32'(sus_req), 0);
        chk("R10 reset undef", 32'(blk_undef), 0);
        rd_blk = 3; #1; chk("R5 idle read", 32'(rd_ok), 1);
        @(negedge clk);

        // R1: plain erase
        start_erase(2, 5);
        count_in(1, n);
        chk("R1 erase length", n, 5);
        chk("R1 done pulse", 32'(done), 1);
        chk("R1 idle after erase", 32'(state_oh), 32'h1);
        @(negedge clk); chk("R1 done width", 32'(done), 0);

        // R1: zero duration
        start_erase(0, 0);
        count_in(1, n);
        chk("R1 zero length", n, 1);

        // R3/R4/R5/R6: software pause and resume
        start_erase(3, 30);
        rd_blk = 4; #1; chk("R5 read while erasing", 32'(rd_ok), 0);
        pre = 0;
        repeat (10) begin if (state_oh[1]) pre++; @(negedge clk); end
        pulse_sus(1); pre++;
        chk("R3 sw set", 32'(sus_req), 1);
        count_in(1, n); pre += n;
        count_in(2, n);
        chk("R4 latency", n, SUS_LAT);
        chk("R4 suspended", 32'(state_oh), 32'h8);
        rd_blk = 3; #1; chk("R5 erased block", 32'(rd_ok), 0);
        rd_blk = 4; #1; chk("R5 other block", 32'(rd_ok), 1);
        repeat (5) @(negedge clk);
        chk("R6 held", 32'(state_oh), 32'h8);
        pulse_sus(0);
        chk("R6 cleared", 32'(sus_req), 0);
        @(negedge clk);
        count_in(1, n);
        chk("R6 total erase", pre + n, 31);
        chk("R6 done", 32'(done), 1);

        // R2: auto suspend off then on, then R8/R9 abort from SUSPENDED
        auto_sus_en = 0;
        start_erase(1, 20);
        irq_ack_mask = 1; @(negedge clk); irq_ack_mask = 0;
        chk("R2 auto off", 32'(sus_req), 0);
        auto_sus_en = 1;
        irq_ack_mask = 1; @(negedge clk); irq_ack_mask = 0;
        chk("R2 auto on", 32'(sus_req), 1);
        auto_sus_en = 0;
        while (!state_oh[3]) @(negedge clk);
        irq_ack_nmi = 1; @(negedge clk); irq_ack_nmi = 0;
        count_in(5, n);
        chk("R8 restart period", n, RST_CYC);
        chk("R8 no done", 32'(done), 0);
        chk("R9 undef set", 32'(blk_undef), 32'h02);

        // R7/R3: program ignores suspend writes
        start_prog(5, 8);
        pulse_sus(1);
        chk("R7 no sus in prog", 32'(sus_req), 0);
        count_in(4, n);
        chk("R7 program length", n, 7);
        chk("R7 done", 32'(done), 1);

        // R8/R9: abort program, then erase clears the flag
        start_prog(6, 40);
        repeat (3) @(negedge clk);
        irq_ack_nmi = 1; @(negedge clk); irq_ack_nmi = 0;
        chk("R8 abort prog", 32'(state_oh), 32'h20);
        chk("R9 undef prog", 32'(blk_undef), 32'h42);
        while (!state_oh[0]) @(negedge clk);
        start_erase(6, 4);
        count_in(1, n);
        chk("R9 undef cleared", 32'(blk_undef), 32'h02);

        // R11: simultaneous commands and commands while busy
        cmd_erase = 1; cmd_prog = 1; cmd_blk = 7; erase_cycles = 6; prog_cycles = 3;
        @(negedge clk); cmd_erase = 0; cmd_prog = 0;
        chk("R11 erase wins", 32'(state_oh), 32'h2);
        cmd_prog = 1; @(negedge clk); cmd_prog = 0;
        chk("R11 busy ignores", 32'(state_oh), 32'h2);
        count_in(1, n);
        chk("R11 erase length kept", n + 1, 6);

        // random traffic compared against the model
        for (int i = 0; i < 4000; i++) begin
            cmd_erase    = ($urandom % 100) < 6;
            cmd_prog     = ($urandom % 100) < 6;
            cmd_blk      = BLK_W'($urandom);
            erase_cycles = CNT_W'($urandom % 40);
            prog_cycles  = CNT_W'($urandom % 20);
            auto_sus_en  = ($urandom % 4) == 0;
            sus_wr_en    = ($urandom % 100) < 6;
            sus_wr_val   = ($urandom % 3) != 0;
            irq_ack_mask = ($urandom % 100) < 5;
            irq_ack_nmi  = ($urandom % 1000) < 8;
            rd_blk       = BLK_W'($urandom);
            @(negedge clk);
        end
        cmd_erase = 0; cmd_prog = 0; sus_wr_en = 0; irq_ack_mask = 0; irq_ack_nmi = 0;
        repeat (3) @(negedge clk);
        wrap_up();
    end
endmodule